// File: doc/BRIEF.md
# Transfer Ring Descriptor Dequeue Engine

This engine walks a segmented circular ring of 128-bit work entries held in external memory, the way a USB host controller consumes its transfer and command rings. A start pulse begins a walk at the current dequeue pointer. The engine reads one entry at a time through a simple request/response memory port. Ownership is decided by comparing each entry's cycle bit with a consumer cycle state held inside the engine. Entries of the jump type are absorbed: they redirect the pointer to another segment and can invert the cycle state. Every other owned entry is streamed out with the address it came from. The walk ends when an entry arrives with its chain bit clear.

When the walk stops, the engine pulses a done strobe with a status code. The code reports a complete descriptor, no descriptor (ring empty, or the descriptor is not yet complete), a pointer overflow, or a memory read error. Entries that were already streamed before a non-complete status are the downstream consumer's to discard. The dequeue pointer and the cycle state can be loaded while the engine is idle and can be read back at all times.

Top module: `trb_ring_walker`

## Requirements
- R1: After reset the dequeue pointer and the cycle state are zero, and busy, memReqValid, outValid and doneValid are low.
- R2: A ptrWrEn or cycWrEn pulse while idle loads its value, which reads back on the next cycle. A write in the same cycle as start is applied, and that walk begins from the new value. Writes while busy are ignored.
- R3: Entry bit 96 is the cycle bit. When it differs from the cycle state, the walk stops with status 1 (no descriptor), and the pointer stays on that entry.
- R4: An owned entry whose bits 111:106 equal 6 is a jump. It is never emitted, and the pointer is loaded with entry bits ADDR_W-1:0 with the low 4 bits cleared.
- R5: A jump entry with bit 97 set inverts the cycle state. With bit 97 clear, the cycle state is unchanged.
- R6: Every other owned entry is emitted on outTrb together with its read address on outAddr, and the pointer advances by 16.
- R7: An emitted entry whose bit 100 (chain) is clear ends the walk with status 0 (complete) once that entry has been accepted.
- R8: A cycle mismatch after a chained entry has been emitted also ends the walk with status 1.
- R9: If advancing the pointer by 16 would overflow ADDR_W bits, the walk stops with status 2. Nothing is emitted, and the pointer is unchanged.
- R10: A read response flagged with memRspErr stops the walk with status 3. The pointer and cycle state stay where the walk reached.
- R11: While outValid is high and outReady is low, outTrb and outAddr hold steady and no memory request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (taken while idle) |
| ptrWrEn | input | 1 | Load dequeue pointer |
| ptrWrData | input | ADDR_W | Pointer value to load |
| cycWrEn | input | 1 | Load cycle state |
| cycWrData | input | 1 | Cycle state value to load |
| dqPtr | output | ADDR_W | Current dequeue pointer |
| cycState | output | 1 | Current consumer cycle state |
| busy | output | 1 | Walk in progress |
| memReqValid | output | 1 | Read request valid |
| memReqReady | input | 1 | Memory accepts request |
| memReqAddr | output | ADDR_W | Read address |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 128 | Entry read from memory |
| memRspErr | input | 1 | Read failed |
| outValid | output | 1 | Emitted entry valid |
| outReady | input | 1 | Downstream accepts entry |
| outTrb | output | 128 | Emitted entry |
| outAddr | output | ADDR_W | Address the entry was read from |
| doneValid | output | 1 | One-cycle end-of-walk strobe |
| doneStatus | output | 2 | 0 complete, 1 none, 2 pointer overflow, 3 read error |

## Verification
A register load and a start can land in the same cycle. The bench drives both on one edge with a new pointer, then judges by the address of the first memory request and the entries emitted. The same walk must come out as if the load had been made a cycle earlier. The opposite case is also covered: a pointer load issued while a walk is stalled on outReady must not disturb the pointer the walk leaves behind.

// File: rtl/trb_walk_pkg.sv
package trb_walk_pkg;
  localparam int TRB_W      = 128;
  localparam int TRB_BYTES  = TRB_W / 8;
  localparam int CYC_BIT    = 96;
  localparam int TOG_BIT    = 97;
  localparam int CHAIN_BIT  = 100;
  localparam int TYPE_LO    = 106;
  localparam int TYPE_W     = 6;
  localparam logic [TYPE_W-1:0] JUMP_TYPE = 6'd6;

  typedef enum logic [1:0] {
    ST_COMPLETE = 2'd0,
    ST_NONE     = 2'd1,
    ST_BADPTR   = 2'd2,
    ST_RDERR    = 2'd3
  } walk_status_e;

  typedef struct packed {
    logic regWrOk;
    logic takeJump;
    logic takeData;
  } walk_strb_t;
endpackage

// File: rtl/trb_walk_dpath.sv
module trb_walk_dpath
  import trb_walk_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  walk_strb_t        strb,
  input  logic              ptrWrEn,
  input  logic [ADDR_W-1:0] ptrWrData,
  input  logic              cycWrEn,
  input  logic              cycWrData,
  input  logic [TRB_W-1:0]  memRspData,
  output logic [ADDR_W-1:0] dqPtr,
  output logic              cycState,
  output logic              cycleOk,
  output logic              isJump,
  output logic              advOvf,
  output logic              capChain,
  output logic [TRB_W-1:0]  capTrb,
  output logic [ADDR_W-1:0] capAddr
);
  localparam int ALIGN = $clog2(TRB_BYTES);

  logic [ADDR_W:0]   advSum;
  logic [ADDR_W-1:0] jumpTarget;

  assign advSum     = {1'b0, dqPtr} + (ADDR_W+1)'(TRB_BYTES);
  assign advOvf     = advSum[ADDR_W];
  assign cycleOk    = memRspData[CYC_BIT] == cycState;
  assign isJump     = memRspData[TYPE_LO +: TYPE_W] == JUMP_TYPE;
  assign jumpTarget = {memRspData[ADDR_W-1:ALIGN], {ALIGN{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dqPtr    <= '0;
      cycState <= 1'b0;
      capChain <= 1'b0;
      capTrb   <= '0;
      capAddr  <= '0;
    end else begin
      if (strb.regWrOk) begin
        if (ptrWrEn) dqPtr    <= ptrWrData;
        if (cycWrEn) cycState <= cycWrData;
      end
      if (strb.takeJump) begin
        dqPtr    <= jumpTarget;
        cycState <= cycState ^ memRspData[TOG_BIT];
      end
      if (strb.takeData) begin
        dqPtr    <= advSum[ADDR_W-1:0];
        capTrb   <= memRspData;
        capAddr  <= dqPtr;
        capChain <= memRspData[CHAIN_BIT];
      end
    end
  end

  a_r6_advance_by_entry: assert property (@(posedge clk) disable iff (!rstN)
    strb.takeData |=> (capAddr + ADDR_W'(TRB_BYTES)) == dqPtr);
  a_r5_toggle_on_jump: assert property (@(posedge clk) disable iff (!rstN)
    strb.takeJump |=> cycState == ($past(cycState) ^ $past(memRspData[TOG_BIT])));
endmodule

// File: rtl/trb_walk_ctrl.sv
module trb_walk_ctrl
  import trb_walk_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         memReqReady,
  input  logic         memRspValid,
  input  logic         memRspErr,
  input  logic         cycleOk,
  input  logic         isJump,
  input  logic         advOvf,
  input  logic         capChain,
  input  logic         outReady,
  output walk_strb_t   strb,
  output logic         memReqValid,
  output logic         outValid,
  output logic         busy,
  output logic         doneValid,
  output walk_status_e doneStatus
);
  typedef enum logic [2:0] {S_IDLE, S_REQ, S_WAIT, S_EMIT, S_FIN} state_e;
  state_e state, stateNxt;
  walk_status_e statusNxt;

  always_comb begin
    stateNxt      = state;
    statusNxt     = doneStatus;
    strb          = '0;
    strb.regWrOk  = state == S_IDLE;
    unique case (state)
      S_IDLE: if (start) stateNxt = S_REQ;
      S_REQ:  if (memReqReady) stateNxt = S_WAIT;
      S_WAIT: if (memRspValid) begin
        if (memRspErr) begin
          statusNxt = ST_RDERR;  stateNxt = S_FIN;
        end else if (!cycleOk) begin
          statusNxt = ST_NONE;   stateNxt = S_FIN;
        end else if (isJump) begin
          strb.takeJump = 1'b1;  stateNxt = S_REQ;
        end else if (advOvf) begin
          statusNxt = ST_BADPTR; stateNxt = S_FIN;
        end else begin
          strb.takeData = 1'b1;  stateNxt = S_EMIT;
        end
      end
      S_EMIT: if (outReady) begin
        if (capChain) stateNxt = S_REQ;
        else begin
          statusNxt = ST_COMPLETE; stateNxt = S_FIN;
        end
      end
      S_FIN:  stateNxt = S_IDLE;
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      doneStatus <= ST_COMPLETE;
    end else begin
      state      <= stateNxt;
      doneStatus <= statusNxt;
    end
  end

  assign memReqValid = state == S_REQ;
  assign outValid    = state == S_EMIT;
  assign doneValid   = state == S_FIN;
  assign busy        = state != S_IDLE;

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReqValid && !outValid && !doneValid);
  a_r3_mismatch_ends: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT && memRspValid && !memRspErr && !cycleOk) |=> doneValid && doneStatus == ST_NONE);
  a_r7_complete_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneStatus == ST_COMPLETE) |-> $past(outValid && outReady));
endmodule

// File: rtl/trb_ring_walker.sv
module trb_ring_walker
  import trb_walk_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              ptrWrEn,
  input  logic [ADDR_W-1:0] ptrWrData,
  input  logic              cycWrEn,
  input  logic              cycWrData,
  output logic [ADDR_W-1:0] dqPtr,
  output logic              cycState,
  output logic              busy,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [127:0]      memRspData,
  input  logic              memRspErr,
  output logic              outValid,
  input  logic              outReady,
  output logic [127:0]      outTrb,
  output logic [ADDR_W-1:0] outAddr,
  output logic              doneValid,
  output logic [1:0]        doneStatus
);
  walk_strb_t   strb;
  walk_status_e statusE;
  logic cycleOk, isJump, advOvf, capChain;

  trb_walk_ctrl uCtrl (
    .clk, .rstN, .start, .memReqReady, .memRspValid, .memRspErr,
    .cycleOk, .isJump, .advOvf, .capChain, .outReady,
    .strb, .memReqValid, .outValid, .busy, .doneValid,
    .doneStatus(statusE)
  );

  trb_walk_dpath #(.ADDR_W(ADDR_W)) uDpath (
    .clk, .rstN, .strb, .ptrWrEn, .ptrWrData, .cycWrEn, .cycWrData,
    .memRspData, .dqPtr, .cycState, .cycleOk, .isJump, .advOvf,
    .capChain, .capTrb(outTrb), .capAddr(outAddr)
  );

  assign memReqAddr = dqPtr;
  assign doneStatus = statusE;

  a_r11_hold_under_stall: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid && $stable(outTrb) && $stable(outAddr) && !memReqValid);
  a_r4_jump_not_emitted: assert property (@(posedge clk) disable iff (!rstN)
    (memRspValid && !memRspErr && cycleOk && isJump && busy && !outValid) |=> !outValid);
endmodule

// File: tb/trb_ring_walker_test.sv
module trb_ring_walker_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic clk = 0, rstN = 0;
  logic start = 0, ptrWrEn = 0, cycWrEn = 0, cycWrData = 0;
  logic [AW-1:0] ptrWrData = '0;
  logic [AW-1:0] dqPtr, memReqAddr, outAddr;
  logic cycState, busy, memReqValid, outValid, doneValid;
  logic memReqReady = 1, memRspValid = 0, memRspErr = 0, outReady = 1;
  logic [127:0] memRspData = '0, outTrb;
  logic [1:0] doneStatus;

  int errors = 0, checks = 0;
  logic [127:0] mem [0:63];
  logic errOn = 0;
  logic [AW-1:0] errAddr = '0;
  int nOut = 0;
  logic [63:0] gotParam [0:15];
  logic [AW-1:0] gotAddr [0:15];
  logic [AW-1:0] firstReq;
  logic sawFirstReq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trb_ring_walker #(.ADDR_W(AW)) uut (.*);

  always @(posedge clk) begin
    if (memReqValid && memReqReady) begin
      memRspValid <= 1'b1;
      memRspData  <= mem[memReqAddr[9:4]];
      memRspErr   <= errOn && memReqAddr == errAddr;
      if (!sawFirstReq) begin firstReq <= memReqAddr; sawFirstReq <= 1'b1; end
    end else begin
      memRspValid <= 1'b0;
    end
    if (outValid && outReady && nOut < 16) begin
      gotParam[nOut] <= outTrb[63:0];
      gotAddr[nOut]  <= outAddr;
      nOut <= nOut + 1;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1; checks = checks + 1;
      $display("FAIL watchdog: run hung (actual running, expected finished)");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [127:0] mkData(input logic [63:0] p, input logic ch, input logic cb);
    logic [127:0] t = '0;
    t[63:0] = p; t[111:106] = 6'd1; t[100] = ch; t[96] = cb;
    return t;
  endfunction

  function automatic logic [127:0] mkJump(input logic [63:0] seg, input logic tog, input logic cb);
    logic [127:0] t = '0;
    t[63:0] = seg; t[111:106] = 6'd6; t[97] = tog; t[96] = cb;
    return t;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 64; i++) mem[i] = '0;
    errOn = 0;
  endtask

  task automatic setRegs(input logic [AW-1:0] p, input logic c);
    @(negedge clk);
    ptrWrEn = 1; ptrWrData = p; cycWrEn = 1; cycWrData = c;
    @(negedge clk);
    ptrWrEn = 0; cycWrEn = 0;
  endtask

  task automatic runWalk(output logic [1:0] st);
    @(negedge clk);
    nOut = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    for (int k = 0; k < 500; k++) begin
      if (doneValid) break;
      @(negedge clk);
    end
    st = doneStatus;
  endtask

  task automatic loadSegments();
    clearMem();
    mem[16] = mkData(1, 1, 0); mem[17] = mkData(2, 1, 0); mem[18] = mkJump(16'h200, 0, 0);
    mem[32] = mkData(3, 1, 0); mem[33] = mkData(4, 0, 0); mem[34] = mkJump(16'h300, 0, 0);
    mem[48] = mkData(5, 1, 0); mem[49] = mkData(6, 0, 0); mem[50] = mkJump(16'h100, 0, 0);
  endtask

  task automatic testReset();
    chk("R1 ptr", dqPtr, 0);
    chk("R1 cycle", cycState, 0);
    chk("R1 quiet", {busy, memReqValid, outValid, doneValid}, 0);
  endtask

  task automatic testSegments();
    logic [1:0] st;
    loadSegments();
    setRegs(16'h100, 0);
    chk("R2 readback", dqPtr, 16'h100);
    runWalk(st);
    chk("R7 complete", st, 0);
    chk("R4 jump skipped count", nOut, 4);
    for (int i = 0; i < 4; i++) chk("R6 param", gotParam[i], i + 1);
    chk("R6 addr0", gotAddr[0], 16'h100);
    chk("R6 addr1", gotAddr[1], 16'h110);
    chk("R4 addr after jump", gotAddr[2], 16'h200);
    chk("R6 final ptr", dqPtr, 16'h220);
    runWalk(st);
    chk("R7 second complete", st, 0);
    chk("R4 second count", nOut, 2);
    chk("R6 second param", gotParam[0], 5);
    chk("R6 second ptr", dqPtr, 16'h320);
  endtask

  task automatic testStallAndBusyWrite();
    logic [1:0] st;
    loadSegments();
    setRegs(16'h100, 0);
    outReady = 0;
    @(negedge clk); nOut = 0; start = 1;
    @(negedge clk); start = 0;
    for (int k = 0; k < 50 && !outValid; k++) @(negedge clk);
    ptrWrEn = 1; ptrWrData = 16'h3A0; cycWrEn = 1; cycWrData = 1;
    @(negedge clk); ptrWrEn = 0; cycWrEn = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R11 no request during stall", memReqValid, 0);
      chk("R11 entry held", outTrb[63:0], 1);
    end
    outReady = 1;
    for (int k = 0; k < 500; k++) begin
      if (doneValid) break;
      @(negedge clk);
    end
    st = doneStatus;
    chk("R11 complete after stall", st, 0);
    chk("R2 busy write ignored ptr", dqPtr, 16'h220);
    chk("R2 busy write ignored cycle", cycState, 0);
  endtask

  task automatic testWriteWithStart();
    logic [1:0] st;
    loadSegments();
    setRegs(16'h100, 0);
    @(negedge clk);
    sawFirstReq = 0; nOut = 0;
    ptrWrEn = 1; ptrWrData = 16'h300; start = 1;
    @(negedge clk);
    ptrWrEn = 0; start = 0;
    for (int k = 0; k < 500; k++) begin
      if (doneValid) break;
      @(negedge clk);
    end
    st = doneStatus;
    chk("R2 first request uses new ptr", firstReq, 16'h300);
    chk("R2 walk from new ptr", gotParam[0], 5);
    chk("R2 status", st, 0);
  endtask

  task automatic testIncomplete();
    logic [1:0] st;
    clearMem();
    mem[16] = mkData(1, 1, 0); mem[17] = mkData(2, 1, 0); mem[18] = mkJump(16'h200, 1, 0);
    mem[32] = mkData(3, 1, 0);
    setRegs(16'h100, 0);
    runWalk(st);
    chk("R8 none status", st, 1);
    chk("R8 emitted before stop", nOut, 2);
    chk("R3 ptr stays", dqPtr, 16'h200);
    chk("R5 toggled", cycState, 1);
  endtask

  task automatic testEmpty();
    logic [1:0] st;
    clearMem();
    mem[0] = mkData(9, 0, 1);
    setRegs(16'h000, 0);
    runWalk(st);
    chk("R3 empty status", st, 1);
    chk("R3 nothing emitted", nOut, 0);
    chk("R3 ptr unchanged", dqPtr, 0);
  endtask

  task automatic testToggle();
    logic [1:0] st;
    clearMem();
    mem[16] = mkData(1, 0, 0); mem[17] = mkJump(16'h100, 1, 0);
    setRegs(16'h100, 0);
    runWalk(st);
    chk("R7 first", st, 0);
    chk("R5 cycle not yet toggled", cycState, 0);
    mem[16] = mkData(2, 0, 1);
    runWalk(st);
    chk("R6 wrapped param", gotParam[0], 2);
    chk("R5 toggled to 1", cycState, 1);
    mem[17] = mkJump(16'h100, 1, 1); mem[16] = mkData(3, 0, 0);
    runWalk(st);
    chk("R6 third param", gotParam[0], 3);
    chk("R5 toggled back", cycState, 0);
    mem[17] = mkJump(16'h100, 0, 0); mem[16] = mkData(4, 0, 0);
    runWalk(st);
    chk("R5 no toggle flag", cycState, 0);
    chk("R5 no toggle param", gotParam[0], 4);
  endtask

  task automatic testOverflow();
    logic [1:0] st;
    clearMem();
    mem[63] = mkData(7, 0, 0);
    setRegs(16'hFFF0, 0);
    runWalk(st);
    chk("R9 status", st, 2);
    chk("R9 nothing emitted", nOut, 0);
    chk("R9 ptr unchanged", dqPtr, 16'hFFF0);
  endtask

  task automatic testReadErr();
    logic [1:0] st;
    clearMem();
    mem[16] = mkData(1, 1, 0); mem[17] = mkData(2, 0, 0);
    errOn = 1; errAddr = 16'h110;
    setRegs(16'h100, 0);
    runWalk(st);
    chk("R10 status", st, 3);
    chk("R10 emitted before error", nOut, 1);
    chk("R10 ptr where reached", dqPtr, 16'h110);
    errOn = 0;
  endtask

  initial begin
    clearMem();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testSegments();
    testStallAndBusyWrite();
    testWriteWithStart();
    testIncomplete();
    testEmpty();
    testToggle();
    testOverflow();
    testReadErr();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule